// File: doc/BRIEF.md
# Masked Address/Data Breakpoint Channel

This block is one hardware breakpoint channel. It watches bus accesses and raises a one-clock match pulse when an access hits a programmed address and data pattern. Software sets up the channel through a small register port. The port holds a break address, an address mask, a break data word, a data mask and a source-select control word.

The control word names the data source for the compare. The source is one of two 32-bit system buses (instruction side and internal) or one of two 16-bit memory buses (X and Y). The two 16-bit buses use opposite halves of the break data word, and the half a memory bus does not use plays no part in the compare. Every mask bit set to 1 removes the matching bit from the compare.

Address and data must both agree for a match. The pulse appears on the clock after the access. Exception entry, chained conditions and hit counters are handled elsewhere.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset every register reads back zero and `brk_match` is low.
- R2: A write with `reg_we` high stores `reg_wdata` at the clock edge. `reg_rdata` shows the register chosen by `reg_sel` one clock later. Index 0 is the break address, 1 the address mask, 2 the break data, 3 the data mask and 4 the control word (bits 3..0, upper bits read 0). Other indexes read zero.
- R3: Address bits whose mask bit is 1 are ignored. Bits whose mask bit is 0 must equal the break address.
- R4: The compare is off when control bit 2 is 0 and control bits 1..0 are 00 or 11. No match is then reported.
- R5: Control bits 1..0 = 01 with bit 2 = 0 compares all 32 break data bits against `ibus_data`.
- R6: Control bits 1..0 = 10 with bit 2 = 0 compares all 32 break data bits against `lbus_data`.
- R7: Control bit 2 = 1 with bit 3 = 0 compares `xbus_data[15:0]` against break data bits 31..16. Break data bits 15..0 are ignored.
- R8: Control bit 2 = 1 with bit 3 = 1 compares `ybus_data[15:0]` against break data bits 15..0. Break data bits 31..16 are ignored.
- R9: A data mask bit of 1 drops that break data bit from the compare. The mask is applied in the break data word's own bit positions, after the lane mapping.
- R10: When control bit 2 is 1, the memory-bus choice overrides control bits 1..0.
- R11: `brk_match` is high for exactly one clock, the clock after an access with `acc_valid` high whose masked address and masked data both agree. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_addr | input | 32 | Address of the access |
| ibus_data | input | 32 | Instruction-side bus data |
| lbus_data | input | 32 | Internal system bus data |
| xbus_data | input | 16 | X memory bus data |
| ybus_data | input | 16 | Y memory bus data |
| brk_match | output | 1 | One-clock match pulse |

## Verification
Each source is tried with data that agrees on the selected bus while the other buses carry conflicting values. This separates correct source selection from a compare against the wrong bus. The memory-bus cases put a matching value in one half of the break data and garbage in the other, then swap the halves. A lane swap or a compare over the full word therefore shows up. Partial masks, full masks and no masks are run against addresses that differ only inside or only outside the masked bits. Idle and disabled cycles that carry otherwise matching patterns show that both the valid qualifier and the enable gate are applied.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_IBUS = 3'd1,
    SRC_LBUS = 3'd2,
    SRC_XMEM = 3'd3,
    SRC_YMEM = 3'd4
  } src_e;

  localparam logic [2:0] IDX_BADDR = 3'd0;
  localparam logic [2:0] IDX_AMASK = 3'd1;
  localparam logic [2:0] IDX_BDATA = 3'd2;
  localparam logic [2:0] IDX_DMASK = 3'd3;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam int CTRL_W = 4;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      baddr,
  output logic [W-1:0]      amask,
  output logic [W-1:0]      bdata,
  output logic [W-1:0]      dmask,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baddr <= '0;
      amask <= '0;
      bdata <= '0;
      dmask <= '0;
      ctrl  <= '0;
    end else if (we) begin
      case (sel)
        IDX_BADDR: baddr <= wdata;
        IDX_AMASK: amask <= wdata;
        IDX_BDATA: bdata <= wdata;
        IDX_DMASK: dmask <= wdata;
        IDX_CTRL:  ctrl  <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (sel)
        IDX_BADDR: rdata <= baddr;
        IDX_AMASK: rdata <= amask;
        IDX_BDATA: rdata <= bdata;
        IDX_DMASK: rdata <= dmask;
        IDX_CTRL:  rdata <= {{(W-CTRL_W){1'b0}}, ctrl};
        default:   rdata <= '0;
      endcase
    end
  end

  assert_addr_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel == IDX_BADDR) |=> (baddr == $past(wdata)));
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (amask == '0 && bdata == '0 && dmask == '0));
endmodule

// File: rtl/brk_lane.sv
module brk_lane
  import brk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [W-1:0]      ibus,
  input  logic [W-1:0]      lbus,
  input  logic [W/2-1:0]    xbus,
  input  logic [W/2-1:0]    ybus,
  input  logic [W-1:0]      dmask,
  output logic              en,
  output logic [W-1:0]      cmp_data,
  output logic [W-1:0]      cmp_mask
);
  localparam int HW = W / 2;
  src_e src;

  always_comb begin
    if (ctrl[2]) src = ctrl[3] ? SRC_YMEM : SRC_XMEM;
    else begin
      case (ctrl[1:0])
        2'b01:   src = SRC_IBUS;
        2'b10:   src = SRC_LBUS;
        default: src = SRC_OFF;
      endcase
    end
  end

  always_comb begin
    en       = (src != SRC_OFF);
    cmp_data = '0;
    cmp_mask = dmask;
    case (src)
      SRC_IBUS: cmp_data = ibus;
      SRC_LBUS: cmp_data = lbus;
      SRC_XMEM: begin
        cmp_data = {xbus, {HW{1'b0}}};
        cmp_mask = dmask | {{HW{1'b0}}, {HW{1'b1}}};
      end
      SRC_YMEM: begin
        cmp_data = {{HW{1'b0}}, ybus};
        cmp_mask = dmask | {{HW{1'b1}}, {HW{1'b0}}};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         en,
  input  logic [W-1:0] acc_addr,
  input  logic [W-1:0] baddr,
  input  logic [W-1:0] amask,
  input  logic [W-1:0] cmp_data,
  input  logic [W-1:0] bdata,
  input  logic [W-1:0] cmp_mask,
  output logic         hit
);
  logic addr_ok, data_ok;

  always_comb begin
    addr_ok = (((acc_addr ^ baddr) & ~amask) == '0);
    data_ok = (((cmp_data ^ bdata) & ~cmp_mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= valid && en && addr_ok && data_ok;
  end

  assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(valid));
  assert_off_is_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !hit);
  assert_full_mask_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && en && (&amask) && (&cmp_mask)) |=> hit);
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [2:0]     reg_sel,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic           acc_valid,
  input  logic [W-1:0]   acc_addr,
  input  logic [W-1:0]   ibus_data,
  input  logic [W-1:0]   lbus_data,
  input  logic [W/2-1:0] xbus_data,
  input  logic [W/2-1:0] ybus_data,
  output logic           brk_match
);
  logic [W-1:0]      baddr, amask, bdata, dmask, cmp_data, cmp_mask;
  logic [CTRL_W-1:0] ctrl;
  logic              en;

  brk_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .baddr(baddr), .amask(amask), .bdata(bdata),
    .dmask(dmask), .ctrl(ctrl)
  );

  brk_lane #(.W(W)) u_lane (
    .ctrl(ctrl), .ibus(ibus_data), .lbus(lbus_data), .xbus(xbus_data),
    .ybus(ybus_data), .dmask(dmask), .en(en), .cmp_data(cmp_data),
    .cmp_mask(cmp_mask)
  );

  brk_match #(.W(W)) u_match (
    .clk(clk), .rst(rst), .valid(acc_valid), .en(en), .acc_addr(acc_addr),
    .baddr(baddr), .amask(amask), .cmp_data(cmp_data), .bdata(bdata),
    .cmp_mask(cmp_mask), .hit(brk_match)
  );

  assert_pulse_one_clock_R11: assert property (@(posedge clk) disable iff (rst)
    (brk_match && !$past(acc_valid, 1)) |-> 1'b0);
endmodule

// File: tb/brk_cmp_top_bench.sv
module brk_cmp_top_bench;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst = 1, reg_we = 0, acc_valid = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, acc_addr = 0, ibus_data = 0, lbus_data = 0;
  logic [15:0] xbus_data = 0, ybus_data = 0;
  logic [31:0] reg_rdata;
  logic        brk_match;

  int checks = 0, errors = 0;
  bit done = 0;

  brk_cmp_top u_brk_cmp_top (.*);

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_reg [0:4];
  logic        exp_match;
  logic [31:0] exp_rdata;

  function automatic bit ref_hit();
    bit ok = 1;
    logic [3:0] c = m_reg[4][3:0];
    int mode;
    if (!acc_valid) return 0;
    for (int i = 0; i < 32; i++)
      if (!m_reg[1][i] && acc_addr[i] != m_reg[0][i]) ok = 0;
    if (c[2]) mode = c[3] ? 4 : 3;
    else if (c[1:0] == 2'b01) mode = 1;
    else if (c[1:0] == 2'b10) mode = 2;
    else return 0;
    for (int i = 0; i < 32; i++) begin
      bit want;
      bit care = !m_reg[3][i];
      case (mode)
        1: want = ibus_data[i];
        2: want = lbus_data[i];
        3: begin want = (i >= 16) ? xbus_data[i-16] : 1'b0; if (i < 16) care = 0; end
        default: begin want = (i < 16) ? ybus_data[i] : 1'b0; if (i >= 16) care = 0; end
      endcase
      if (care && want != m_reg[2][i]) ok = 0;
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) m_reg[i] <= 0;
      exp_match <= 0;
      exp_rdata <= 0;
    end else begin
      exp_match <= ref_hit();
      exp_rdata <= (reg_sel <= 4) ? m_reg[reg_sel] : 32'h0;
      if (reg_we && reg_sel <= 4)
        m_reg[reg_sel] <= (reg_sel == 4) ? {28'h0, reg_wdata[3:0]} : reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (brk_match !== exp_match) begin
        errors++;
        $display("FAIL R11 cycle model: brk_match=%0b expected %0b", brk_match, exp_match);
      end
      checks++;
      if (reg_rdata !== exp_rdata) begin
        errors++;
        $display("FAIL R2 cycle model: reg_rdata=%h expected %h", reg_rdata, exp_rdata);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string req);
    reg_sel = s;
    @(negedge clk);
    chk(reg_rdata, exp, req);
  endtask

  task automatic setup(input logic [31:0] a, am, d, dm, c);
    wr(0, a); wr(1, am); wr(2, d); wr(3, dm); wr(4, c);
  endtask

  task automatic acc(input logic [31:0] a, i, l, input logic [15:0] x, y,
                     input bit exp, input string req);
    acc_valid = 1; acc_addr = a; ibus_data = i; lbus_data = l;
    xbus_data = x; ybus_data = y;
    @(negedge clk);
    chk({31'h0, brk_match}, {31'h0, exp}, req);
    acc_valid = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk({31'h0, brk_match}, 32'h0, "R1 match after reset");
    for (int s = 0; s < 5; s++) rd(s[2:0], 32'h0, "R1 register reset");
    // R2: write and readback
    setup(32'hA5A5_0001, 32'h0000_00F0, 32'h1357_9BDF, 32'h0F0F_0000, 32'hFFFF_FFF9);
    rd(0, 32'hA5A5_0001, "R2 baddr");
    rd(1, 32'h0000_00F0, "R2 amask");
    rd(2, 32'h1357_9BDF, "R2 bdata");
    rd(3, 32'h0F0F_0000, "R2 dmask");
    rd(4, 32'h0000_0009, "R2 ctrl");
    rd(6, 32'h0, "R2 unused index");
    // R5: instruction bus
    setup(32'h0000_1000, 0, 32'hDEAD_BEEF, 0, 32'h1);
    acc(32'h1000, 32'hDEAD_BEEF, 32'h0, 16'h0, 16'h0, 1, "R5 ibus hit");
    @(negedge clk);
    chk({31'h0, brk_match}, 32'h0, "R11 pulse one clock");
    acc(32'h1000, 32'hDEAD_BEEE, 32'hDEAD_BEEF, 16'h0, 16'h0, 0, "R5 ibus bit0 differs");
    acc(32'h1004, 32'hDEAD_BEEF, 32'h0, 16'h0, 16'h0, 0, "R11 addr miss with data hit");
    // R11: valid low
    acc_addr = 32'h1000; ibus_data = 32'hDEAD_BEEF;
    @(negedge clk);
    chk({31'h0, brk_match}, 32'h0, "R11 no valid no match");
    // R3: address mask
    wr(1, 32'h0000_000F);
    acc(32'h100F, 32'hDEAD_BEEF, 0, 0, 0, 1, "R3 masked bits differ");
    acc(32'h1010, 32'hDEAD_BEEF, 0, 0, 0, 0, "R3 unmasked bit differs");
    // R6: internal bus
    wr(4, 32'h2);
    acc(32'h1000, 32'h0, 32'hDEAD_BEEF, 0, 0, 1, "R6 lbus hit");
    acc(32'h1000, 32'hDEAD_BEEF, 32'h5EAD_BEEF, 0, 0, 0, "R6 lbus miss");
    // R4: disabled
    wr(4, 32'h0);
    acc(32'h1000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0, 0, "R4 class 00 off");
    wr(4, 32'h3);
    acc(32'h1000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0, 0, "R4 class 11 off");
    // R7: X lane, low half of break data ignored
    setup(32'h2000, 0, 32'h1234_ABCD, 0, 32'h5);
    acc(32'h2000, 32'h0, 32'h0, 16'h1234, 16'h0, 1, "R7 x high half hit");
    acc(32'h2000, 32'h1234_ABCD, 32'h0, 16'hABCD, 16'h1234, 0, "R7 x low half not used");
    // R8: Y lane plus override R10
    wr(4, 32'hD);
    acc(32'h2000, 32'h0, 32'h0, 16'h0, 16'hABCD, 1, "R8 y low half hit");
    acc(32'h2000, 32'h1234_ABCD, 32'h0, 16'h1234, 16'h1234, 0, "R10 y overrides ibus class");
    wr(4, 32'h6);
    acc(32'h2000, 32'h0, 32'h1234_ABCD, 16'h0, 16'h0, 0, "R10 x overrides lbus class");
    // R9: data mask after lane mapping
    wr(4, 32'hC); wr(3, 32'h0000_000F);
    acc(32'h2000, 0, 0, 0, 16'hABC0, 1, "R9 y masked nibble");
    acc(32'h2000, 0, 0, 0, 16'hABDD, 0, "R9 y unmasked bit");
    wr(4, 32'h4); wr(3, 32'h000F_0000);
    acc(32'h2000, 0, 0, 16'h123F, 0, 1, "R9 x masked at bits 19..16");
    // full mask
    setup(32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h1);
    acc(32'h8765_4321, 32'hCAFE_F00D, 0, 0, 0, 1, "R3 all masked");
    acc_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule